// File: doc/BRIEF.md
# Shared-Memory Load Return Writeback

This block sits between the return queue of a shared-memory pipeline and a per-lane vector register file. It looks at the response at the head of the queue and waits until the response may retire. It then turns each returned memory element into register format and writes it into the destination registers. Each write carries one register index, one value per lane and a lane mask.

A response names a register width (32 or 64 bits) and a memory element type. The element is widened to fit the register. Unsigned integers are zero-extended. Signed integers are sign-extended. Half- and single-precision floats are converted exactly to the wider float format. A response may cover up to `MAX_REGS` consecutive destination registers. For each register, the queue presents that register's lane data, selected by `headSel`. The block writes one register per cycle, and pops the response once its last register has been handled.

Once a response retires, the block keeps the register write bus busy for the number of cycles the response asks for. When co-issued returns are disabled, it also holds the issuing pipe's wait flag for the same number of cycles. Later retirements are gated on both of these.

Top module: `lds_load_writeback`

## Requirements
- R1: An idle block accepts the head response only in a cycle where all of the following hold: `headValid`, `headLatDone` and `rfReady` are high, the bus timer is zero, and either `coissueEn` is high or the wait timer of `headPipe` is zero. In any other idle cycle, `headPop` and `dropErr` stay low.
- R2: Type codes 0, 1, 2 and 3 are unsigned 8, 16, 32 and 64 bits, taken from the low bits of each 64-bit lane slot. They are zero-extended to the register width.
- R3: Type codes 4, 5, 6 and 7 are signed 8, 16, 32 and 64 bits. They are sign-extended to the register width. When `headWide` is 0, the register is 32 bits and bits 63:32 of every lane are zero.
- R4: Type codes 8, 9 and 10 are half, single and double precision. A half converts exactly to single (when `headWide`=0) or to double (when `headWide`=1). A single converts to double when `headWide`=1. Zeros, subnormals and infinities convert exactly. A NaN keeps its sign and its payload, left-aligned.
- R5: An accepted response with `headCntM1`=N produces N+1 writes in consecutive cycles. Write k goes to index `headDst`+k, modulo 2^`REG_IDX_W`. `headSel` equals k in the cycle that write k is taken, and 0 in every other cycle. Each write appears on `wrEn`/`wrIdx`/`wrData`/`wrMask` one cycle after it is taken. `wrMask` equals `headMask`, and is zero when `wrEn` is low.
- R6: Only op code 0 (load) and op code 1 (atomic with return) write registers. Op codes 2 (store) and 3 (other) are popped in the cycle they are accepted, with no write.
- R7: When a legal response is popped with busy time T, the block accepts nothing in the T cycles that follow.
- R8: When a legal response from pipe P is popped while `coissueEn` is 0, pipe P's wait timer is loaded with T. A response from pipe P is then blocked during those T cycles unless `coissueEn` is high. A pop while `coissueEn` is 1 leaves the wait timer alone.
- R9: The following pairs are illegal: type codes 11 to 15, and type codes 3, 7 or 10 with `headWide`=0. On acceptance, such a response is popped with `dropErr` high. It produces no write and loads no timer.
- R10: While `rstN` is low, and in the first cycle after it rises, `wrEn` is low and `wrMask` is zero. Reset clears all timers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| headValid | input | 1 | Return queue holds a response |
| headLatDone | input | 1 | Head response latency has elapsed |
| headOp | input | 2 | Operation kind: 0 load, 1 atomic with return, 2 store, 3 other |
| headWide | input | 1 | Register width: 0 is 32 bits, 1 is 64 bits |
| headType | input | 4 | Memory element type code |
| headCntM1 | input | $clog2(MAX_REGS) | Number of destination registers minus one |
| headDst | input | REG_IDX_W | First destination register index |
| headPipe | input | $clog2(NUM_PIPES) | Issuing pipe of the response |
| headBusyTime | input | TIME_W | Busy duration applied on retirement |
| headMask | input | LANES | Per-lane execution mask |
| headLaneData | input | LANES*64 | Raw lane elements of the selected register, 64 bits per lane |
| headSel | output | $clog2(MAX_REGS) | Register of the head response whose data is requested |
| headPop | output | 1 | Remove the head response |
| rfReady | input | 1 | Register file can take the write |
| coissueEn | input | 1 | Co-issued returns enabled; per-pipe wait is ignored |
| wrEn | output | 1 | Register write strobe |
| wrIdx | output | REG_IDX_W | Register index |
| wrData | output | LANES*64 | Widened lane values |
| wrMask | output | LANES | Lane write enables |
| dropErr | output | 1 | Head response dropped as an illegal width/type pair |

## Verification
The hardest situation to reach from the ports is one where a second response meets the last cycles of an earlier response's bus or pipe hold. It gets harder still when that response comes from the other pipe while `coissueEn` is changing. The stimulus reaches this by drawing busy times of 0 to 3 cycles and pipe ids at random, and by toggling `rfReady`, `headLatDone` and short gaps in `headValid` every cycle. It also runs the sequence in three phases: co-issue off, co-issue on, and co-issue random. A behavioural model in the bench keeps its own timers and compares pop, drop and every write on every clock. Lanes with fixed all-zero and all-one patterns, plus random lanes, cover signed extremes, float zeros, subnormals, infinities and NaNs.

// File: rtl/lrw_pkg.sv
package lrw_pkg;

  typedef enum logic [1:0] {
    OP_LOAD     = 2'd0,
    OP_ATOM_RET = 2'd1,
    OP_STORE    = 2'd2,
    OP_OTHER    = 2'd3
  } opKind_e;

  localparam logic [3:0] TY_U8  = 4'd0;
  localparam logic [3:0] TY_U16 = 4'd1;
  localparam logic [3:0] TY_U32 = 4'd2;
  localparam logic [3:0] TY_U64 = 4'd3;
  localparam logic [3:0] TY_S8  = 4'd4;
  localparam logic [3:0] TY_S16 = 4'd5;
  localparam logic [3:0] TY_S32 = 4'd6;
  localparam logic [3:0] TY_S64 = 4'd7;
  localparam logic [3:0] TY_F16 = 4'd8;
  localparam logic [3:0] TY_F32 = 4'd9;
  localparam logic [3:0] TY_F64 = 4'd10;

  // Control-to-datapath strobes
  typedef struct packed {
    logic wrStb;
    logic popStb;
    logic dropStb;
  } lrwStrobe_t;

  function automatic logic lrwIsLegal(input logic wide, input logic [3:0] typ);
    logic ok;
    ok = (typ <= TY_F64);
    if (!wide && (typ == TY_U64 || typ == TY_S64 || typ == TY_F64)) ok = 1'b0;
    return ok;
  endfunction

  // Exact widening of a half or single value to double precision
  function automatic logic [63:0] lrwFpToDbl(input logic isHalf, input logic [31:0] raw);
    logic        sgn;
    int          expIn;
    int          bias;
    int          expMax;
    int          shift;
    int          expOut;
    logic [22:0] man;
    logic [22:0] manN;
    logic [10:0] expField;
    sgn    = isHalf ? raw[15] : raw[31];
    expIn  = isHalf ? int'(raw[14:10]) : int'(raw[30:23]);
    man    = isHalf ? {raw[9:0], 13'b0} : raw[22:0];
    bias   = isHalf ? 15 : 127;
    expMax = isHalf ? 31 : 255;
    shift  = 0;
    manN   = man;
    expOut = 0;
    if (expIn == expMax) begin
      return {sgn, 11'h7FF, man, 29'b0};
    end else if (expIn == 0 && man == '0) begin
      return {sgn, 63'b0};
    end else if (expIn == 0) begin
      for (int b = 22; b >= 0; b--) begin
        if (man[b] && shift == 0) shift = 23 - b;
      end
      manN   = man << shift;
      expOut = 1 - bias - shift + 1023;
    end else begin
      expOut = expIn - bias + 1023;
    end
    expField = 11'(expOut);
    return {sgn, expField, manN, 29'b0};
  endfunction

  // Narrow a double that came from a half back to single (always exact)
  function automatic logic [31:0] lrwDblToSgl(input logic [63:0] d);
    logic [7:0] expS;
    expS = 8'(d[62:52] - 11'd896);
    if (d[62:52] == 11'h7FF) return {d[63], 8'hFF, d[51:29]};
    if (d[62:0] == '0)       return {d[63], 31'b0};
    return {d[63], expS, d[51:29]};
  endfunction

  function automatic logic [63:0] lrwWiden(input logic wide, input logic [3:0] typ,
                                           input logic [63:0] raw);
    logic [63:0] res;
    logic [63:0] dbl;
    dbl = lrwFpToDbl(typ == TY_F16, raw[31:0]);
    case (typ)
      TY_U8:  res = {56'b0, raw[7:0]};
      TY_U16: res = {48'b0, raw[15:0]};
      TY_U32: res = {32'b0, raw[31:0]};
      TY_S8:  res = {{56{raw[7]}}, raw[7:0]};
      TY_S16: res = {{48{raw[15]}}, raw[15:0]};
      TY_S32: res = {{32{raw[31]}}, raw[31:0]};
      TY_F16: res = wide ? dbl : {32'b0, lrwDblToSgl(dbl)};
      TY_F32: res = wide ? dbl : {32'b0, raw[31:0]};
      default: res = raw;
    endcase
    if (!wide) res[63:32] = '0;
    return res;
  endfunction

endpackage

// File: rtl/lrw_ctrl.sv
module lrw_ctrl
  import lrw_pkg::*;
#(
  parameter int MAX_REGS  = 4,
  parameter int NUM_PIPES = 2,
  parameter int TIME_W    = 4,
  localparam int CW = $clog2(MAX_REGS),
  localparam int PW = $clog2(NUM_PIPES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              headValid,
  input  logic              headLatDone,
  input  logic [1:0]        headOp,
  input  logic              headWide,
  input  logic [3:0]        headType,
  input  logic [CW-1:0]     headCntM1,
  input  logic [PW-1:0]     headPipe,
  input  logic [TIME_W-1:0] headBusyTime,
  input  logic              rfReady,
  input  logic              coissueEn,
  output logic [CW-1:0]     regSel,
  output lrwStrobe_t        stb
);

  logic              inWrite;
  logic [CW-1:0]     regK;
  logic [TIME_W-1:0] busTimer;
  logic [TIME_W-1:0] waitTimer [NUM_PIPES];
  logic              allReady, legal, writesRegs, go, lastReg, timerLoad;
  logic              armed;

  always_comb begin
    legal      = lrwIsLegal(headWide, headType);
    writesRegs = (headOp == OP_LOAD) || (headOp == OP_ATOM_RET);
    allReady   = headValid && headLatDone && rfReady && (busTimer == '0) &&
                 (coissueEn || (waitTimer[headPipe] == '0));
    go         = !inWrite && allReady;
    lastReg    = inWrite ? (regK == headCntM1) : (headCntM1 == '0);
    stb.dropStb = go && !legal;
    stb.wrStb   = (go && legal && writesRegs) || inWrite;
    stb.popStb  = (go && (!legal || !writesRegs || lastReg)) || (inWrite && lastReg);
    regSel      = inWrite ? regK : '0;
    timerLoad   = stb.popStb && !stb.dropStb;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inWrite <= 1'b0;
      regK    <= '0;
    end else if (go && legal && writesRegs && !lastReg) begin
      inWrite <= 1'b1;
      regK    <= CW'(1);
    end else if (inWrite) begin
      if (lastReg) begin
        inWrite <= 1'b0;
        regK    <= '0;
      end else begin
        regK <= regK + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) busTimer <= '0;
    else if (timerLoad) busTimer <= headBusyTime;
    else if (busTimer != '0) busTimer <= busTimer - TIME_W'(1);
  end

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipeWait
    always_ff @(posedge clk) begin
      if (!rstN) waitTimer[p] <= '0;
      else if (timerLoad && !coissueEn && (headPipe == PW'(p))) waitTimer[p] <= headBusyTime;
      else if (waitTimer[p] != '0) waitTimer[p] <= waitTimer[p] - TIME_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else armed <= 1'b1;
  end

  // R1: a pop only ever consumes a present response
  p_pop_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    stb.popStb |-> headValid);
  // R1: an idle block never retires while the register file is not ready
  p_rf_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!inWrite && !rfReady) |-> !stb.popStb);
  // R9: a dropped response writes nothing
  p_drop_nowrite_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.dropStb |-> (stb.popStb && !stb.wrStb));
  // R6: stores and other ops retire without a write
  p_store_nowrite_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!inWrite && stb.popStb && (headOp == OP_STORE || headOp == OP_OTHER)) |-> !stb.wrStb);
  // R7: a nonzero bus hold blocks the next cycle
  p_bus_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(stb.popStb && !stb.dropStb && headBusyTime != '0)) |-> !stb.popStb);

endmodule

// File: rtl/lrw_datapath.sv
module lrw_datapath
  import lrw_pkg::*;
#(
  parameter int LANES     = 64,
  parameter int MAX_REGS  = 4,
  parameter int REG_IDX_W = 8,
  localparam int CW = $clog2(MAX_REGS),
  localparam int DW = LANES * 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  lrwStrobe_t           stb,
  input  logic [CW-1:0]        regSel,
  input  logic                 headWide,
  input  logic [3:0]           headType,
  input  logic [REG_IDX_W-1:0] headDst,
  input  logic [LANES-1:0]     headMask,
  input  logic [DW-1:0]        headLaneData,
  output logic                 wrEn,
  output logic [REG_IDX_W-1:0] wrIdx,
  output logic [DW-1:0]        wrData,
  output logic [LANES-1:0]     wrMask
);

  logic [DW-1:0] widened;
  logic          wideQ;
  logic          upperZero;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign widened[l*64 +: 64] = lrwWiden(headWide, headType, headLaneData[l*64 +: 64]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrEn   <= 1'b0;
      wrIdx  <= '0;
      wrData <= '0;
      wrMask <= '0;
      wideQ  <= 1'b0;
    end else begin
      wrEn <= stb.wrStb;
      if (stb.wrStb) begin
        wrIdx  <= headDst + REG_IDX_W'(regSel);
        wrData <= widened;
        wrMask <= headMask;
        wideQ  <= headWide;
      end else begin
        wrMask <= '0;
      end
    end
  end

  always_comb begin
    upperZero = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      if (wrData[l*64+32 +: 32] != '0) upperZero = 1'b0;
    end
  end

  // R3: 32-bit register results never carry upper bits
  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wideQ) |-> upperZero);
  // R5: no lane enable without a write
  p_mask_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (wrMask == '0));

endmodule

// File: rtl/lds_load_writeback.sv
module lds_load_writeback
  import lrw_pkg::*;
#(
  parameter int LANES     = 64,
  parameter int MAX_REGS  = 4,
  parameter int REG_IDX_W = 8,
  parameter int NUM_PIPES = 2,
  parameter int TIME_W    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          headValid,
  input  logic                          headLatDone,
  input  logic [1:0]                    headOp,
  input  logic                          headWide,
  input  logic [3:0]                    headType,
  input  logic [$clog2(MAX_REGS)-1:0]   headCntM1,
  input  logic [REG_IDX_W-1:0]          headDst,
  input  logic [$clog2(NUM_PIPES)-1:0]  headPipe,
  input  logic [TIME_W-1:0]             headBusyTime,
  input  logic [LANES-1:0]              headMask,
  input  logic [LANES*64-1:0]           headLaneData,
  output logic [$clog2(MAX_REGS)-1:0]   headSel,
  output logic                          headPop,
  input  logic                          rfReady,
  input  logic                          coissueEn,
  output logic                          wrEn,
  output logic [REG_IDX_W-1:0]          wrIdx,
  output logic [LANES*64-1:0]           wrData,
  output logic [LANES-1:0]              wrMask,
  output logic                          dropErr
);

  lrwStrobe_t                stb;
  logic [$clog2(MAX_REGS)-1:0] regSel;

  lrw_ctrl #(
    .MAX_REGS (MAX_REGS),
    .NUM_PIPES(NUM_PIPES),
    .TIME_W   (TIME_W)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .headValid   (headValid),
    .headLatDone (headLatDone),
    .headOp      (headOp),
    .headWide    (headWide),
    .headType    (headType),
    .headCntM1   (headCntM1),
    .headPipe    (headPipe),
    .headBusyTime(headBusyTime),
    .rfReady     (rfReady),
    .coissueEn   (coissueEn),
    .regSel      (regSel),
    .stb         (stb)
  );

  lrw_datapath #(
    .LANES    (LANES),
    .MAX_REGS (MAX_REGS),
    .REG_IDX_W(REG_IDX_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .regSel      (regSel),
    .headWide    (headWide),
    .headType    (headType),
    .headDst     (headDst),
    .headMask    (headMask),
    .headLaneData(headLaneData),
    .wrEn        (wrEn),
    .wrIdx       (wrIdx),
    .wrData      (wrData),
    .wrMask      (wrMask)
  );

  assign headSel = regSel;
  assign headPop = stb.popStb;
  assign dropErr = stb.dropStb;

endmodule

// File: tb/lds_load_writeback_tb_top.sv
module lds_load_writeback_tb_top;

  localparam int LANES = 64;
  localparam int NRESP = 300;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic                 rstN, headValid, headLatDone, headWide, rfReady, coissueEn;
  logic [1:0]           headOp;
  logic [3:0]           headType;
  logic [1:0]           headCntM1;
  logic [7:0]           headDst;
  logic [0:0]           headPipe;
  logic [3:0]           headBusyTime;
  logic [LANES-1:0]     headMask;
  logic [LANES*64-1:0]  headLaneData;
  logic [1:0]           headSel;
  logic                 headPop, wrEn, dropErr;
  logic [7:0]           wrIdx;
  logic [LANES*64-1:0]  wrData;
  logic [LANES-1:0]     wrMask;

  lds_load_writeback dut_i (
    .clk(clk), .rstN(rstN), .headValid(headValid), .headLatDone(headLatDone),
    .headOp(headOp), .headWide(headWide), .headType(headType), .headCntM1(headCntM1),
    .headDst(headDst), .headPipe(headPipe), .headBusyTime(headBusyTime),
    .headMask(headMask), .headLaneData(headLaneData), .headSel(headSel),
    .headPop(headPop), .rfReady(rfReady), .coissueEn(coissueEn), .wrEn(wrEn),
    .wrIdx(wrIdx), .wrData(wrData), .wrMask(wrMask), .dropErr(dropErr)
  );

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  logic [1:0]       qOp   [NRESP];
  logic             qWide [NRESP];
  logic [3:0]       qType [NRESP];
  logic [1:0]       qCnt  [NRESP];
  logic [7:0]       qDst  [NRESP];
  logic [0:0]       qPipe [NRESP];
  logic [3:0]       qBusy [NRESP];
  logic [LANES-1:0] qMask [NRESP];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] laneRaw(input int resp, input int k, input int lane);
    logic [63:0] v;
    if (lane == 0) return 64'h0;
    if (lane == 1) return '1;
    if (lane == 2) return 64'h0000_0000_7F80_7C00;
    if (lane == 3) return 64'h0000_0000_8000_0001;
    v = 64'(resp) * 64'h9E37_79B9_7F4A_7C15 ^ 64'(k) * 64'hC2B2_AE3D_27D4_EB4F ^ 64'(lane) * 64'h1656_67B1_9E37_79F9;
    v = v ^ (v >> 29);
    v = v * 64'hBF58_476D_1CE4_E5B9;
    v = v ^ (v >> 32);
    return v;
  endfunction

  function automatic logic [63:0] refHalfToD(input logic [15:0] h);
    real v;
    int  e, m;
    e = int'(h[14:10]);
    m = int'(h[9:0]);
    if (e == 31) return {h[15], 11'h7FF, h[9:0], 42'b0};
    if (e == 0 && m == 0) return {h[15], 63'b0};
    v = (e == 0) ? real'(m) * 2.0 ** (-24) : real'(1024 + m) * 2.0 ** (e - 25);
    if (h[15]) v = -v;
    return $realtobits(v);
  endfunction

  function automatic logic [63:0] refSglToD(input logic [31:0] s);
    real v;
    int  e, m;
    e = int'(s[30:23]);
    m = int'(s[22:0]);
    if (e == 255) return {s[31], 11'h7FF, s[22:0], 29'b0};
    if (e == 0 && m == 0) return {s[31], 63'b0};
    v = (e == 0) ? real'(m) * 2.0 ** (-149) : real'(8388608 + m) * 2.0 ** (e - 150);
    if (s[31]) v = -v;
    return $realtobits(v);
  endfunction

  function automatic logic [31:0] refDToS(input logic [63:0] d);
    if (d[62:52] == 11'h7FF) return {d[63], 8'hFF, d[51:29]};
    if (d[62:0] == '0) return {d[63], 31'b0};
    return {d[63], 8'(d[62:52] - 11'd896), d[51:29]};
  endfunction

  function automatic logic [63:0] refWiden(input logic wide, input logic [3:0] t, input logic [63:0] r);
    logic [63:0] x;
    case (t)
      4'd0: x = 64'(r[7:0]);
      4'd1: x = 64'(r[15:0]);
      4'd2: x = 64'(r[31:0]);
      4'd3: x = r;
      4'd4: x = 64'(signed'(r[7:0]));
      4'd5: x = 64'(signed'(r[15:0]));
      4'd6: x = 64'(signed'(r[31:0]));
      4'd8: x = wide ? refHalfToD(r[15:0]) : 64'(refDToS(refHalfToD(r[15:0])));
      4'd9: x = wide ? refSglToD(r[31:0]) : 64'(r[31:0]);
      default: x = r;
    endcase
    if (!wide) x = {32'b0, x[31:0]};
    return x;
  endfunction

  function automatic bit refLegal(input logic wide, input logic [3:0] t);
    if (t > 4'd10) return 0;
    if (!wide && (t == 4'd3 || t == 4'd7 || t == 4'd10)) return 0;
    return 1;
  endfunction

  // model state
  int   qh = 0;
  bit   mInW = 0;
  int   mK = 0;
  int   mBus = 0;
  int   mWait [2] = '{0, 0};
  bit   expWrEn = 0;
  logic [7:0] expIdx = '0;
  logic [LANES-1:0] expMask = '0;
  int   expResp = 0;
  int   expRegK = 0;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin : stim
    for (int i = 0; i < NRESP; i++) begin
      qOp[i]   = 2'($urandom % 4);
      if (($urandom % 3) != 0) qOp[i] = 2'($urandom % 2);
      qWide[i] = 1'($urandom % 2);
      qType[i] = (($urandom % 6) == 0) ? 4'($urandom % 16) : 4'($urandom % 11);
      qCnt[i]  = 2'($urandom % 4);
      qDst[i]  = (i % 17 == 5) ? 8'd254 : 8'($urandom % 256);
      qPipe[i] = 1'($urandom % 2);
      qBusy[i] = 4'($urandom % 4);
      qMask[i] = {$urandom, $urandom};
    end
    rstN = 0; headValid = 0; headLatDone = 0; headOp = 0; headWide = 0; headType = 0;
    headCntM1 = 0; headDst = 0; headPipe = 0; headBusyTime = 0; headMask = '0;
    headLaneData = '0; rfReady = 0; coissueEn = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", 64'(wrEn), 64'd0, "wrEn in reset");
    check("R10", 64'(wrMask), 64'd0, "wrMask in reset");
    rstN = 1;
    @(negedge clk);
    check("R10", 64'(wrEn), 64'd0, "wrEn after reset");
    check("R10", 64'(wrMask), 64'd0, "wrMask after reset");
    for (int cyc = 0; cyc < 20000; cyc++) begin
      bit   rdy, legal, writes, pop, drop, gap, wrNow;
      int   kNow, sel;
      logic [3:0] t;
      if (cyc > 0) begin
        if (expWrEn) begin
          t = qType[expResp];
          check("R5", 64'(wrEn), 64'd1, "wrEn");
          check("R5", 64'(wrIdx), 64'(expIdx), "wrIdx");
          check("R5", 64'(wrMask), 64'(expMask), "wrMask");
          for (int l = 0; l < LANES; l++) begin
            check(t < 4 ? "R2" : (t < 8 ? "R3" : "R4"), wrData[l*64 +: 64],
                  refWiden(qWide[expResp], t, laneRaw(expResp, expRegK, l)), "wrData lane");
          end
        end else begin
          check("R6", 64'(wrEn), 64'd0, "wrEn idle");
          check("R5", 64'(wrMask), 64'd0, "wrMask idle");
        end
      end
      if (qh >= NRESP && !mInW) break;
      rfReady     = ($urandom % 4) != 0;
      headLatDone = ($urandom % 5) != 0;
      coissueEn   = (qh < 100) ? 1'b0 : (qh < 200) ? 1'b1 : 1'($urandom % 2);
      gap         = !mInW && (($urandom % 6) == 0);
      headValid   = (qh < NRESP) && !gap;
      sel = mInW ? mK : 0;
      if (qh < NRESP) begin
        headOp = qOp[qh]; headWide = qWide[qh]; headType = qType[qh]; headCntM1 = qCnt[qh];
        headDst = qDst[qh]; headPipe = qPipe[qh]; headBusyTime = qBusy[qh]; headMask = qMask[qh];
        for (int l = 0; l < LANES; l++) headLaneData[l*64 +: 64] = laneRaw(qh, sel, l);
      end
      #1;
      rdy = 0; legal = 0; writes = 0;
      if (qh < NRESP) begin
        legal  = refLegal(qWide[qh], qType[qh]);
        writes = qOp[qh] <= 2'd1;
        rdy = !mInW && headValid && headLatDone && rfReady && mBus == 0 &&
              (coissueEn || mWait[qPipe[qh]] == 0);
      end
      pop = 0; drop = 0; wrNow = 0; kNow = 0;
      if (rdy) begin
        if (!legal) begin pop = 1; drop = 1; end
        else if (!writes) pop = 1;
        else begin
          wrNow = 1; kNow = 0;
          if (qCnt[qh] == 0) pop = 1; else begin mInW = 1; mK = 1; end
        end
      end else if (mInW) begin
        wrNow = 1; kNow = mK;
        if (mK == int'(qCnt[qh])) begin pop = 1; mInW = 0; mK = 0; end
        else mK++;
      end
      check(drop ? "R9" : (mBus != 0 ? "R7" : (mWait[headPipe] != 0 ? "R8" : "R1")),
            64'(headPop), 64'(pop), "headPop");
      check("R9", 64'(dropErr), 64'(drop), "dropErr");
      check("R5", 64'(headSel), 64'(sel), "headSel");
      expWrEn = wrNow;
      if (wrNow) begin
        expResp = qh; expRegK = kNow;
        expIdx  = qDst[qh] + 8'(kNow);
        expMask = qMask[qh];
      end
      if (mBus > 0) mBus--;
      for (int p = 0; p < 2; p++) if (mWait[p] > 0) mWait[p]--;
      if (pop && !drop) begin
        mBus = int'(qBusy[qh]);
        if (!coissueEn) mWait[qPipe[qh]] = int'(qBusy[qh]);
      end
      if (pop) qh++;
      @(negedge clk);
    end
    check("R5", 64'(qh), 64'(NRESP), "responses retired");
    done = 1;
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule